// File: doc/BRIEF.md
# 64-bit PCI Target Read Sequencer

This block is the target-side control for 64-bit memory reads on a PCI bus. It watches the bus for an address phase that requests a 64-bit transfer. It registers the address and command, then decodes the address in the next clock against six parameterised address windows. When a read command hits a window, it claims the cycle and turns on its bus drivers in a fixed order. It then runs the data phases from a single-entry holding register, which a local-side agent fills. At the end it releases the bus in two steps.

Read commands that miss every window, other commands, and requests for 32-bit transfers are left alone. In those cases the block never enables a driver and waits for the bus to go idle. While a claimed cycle is in progress, the local agent sees the registered address, the command and a one-hot window code. The agent supplies data whenever the block is ready to accept it.

The state machine has six states:
- `ST_IDLE`: waits for an address phase.
- `ST_DECODE`: the latched address is decoded.
- `ST_CLAIM`: the drivers are on and every control output is held high.
- `ST_DATA`: DEVSEL# and ACK64# are asserted, and TRDY# follows the holding register.
- `ST_TURN`: every control output is driven high and the AD drivers are off.
- `ST_MISS`: waits for the bus to go idle.

The transitions are:
- IDLE→DECODE when FRAME# is low.
- DECODE→CLAIM on a claimable hit; DECODE→MISS otherwise.
- CLAIM→DATA always.
- DATA→TURN on the final data phase.
- TURN→IDLE always.
- MISS→IDLE when FRAME# and IRDY# are both high.

Top module: `pci64t_rd_target`

## Requirements
- R1: After reset, `ctl_oe`, `ad_oe`, `par_oe` and `loc_claim` are low, and `devsel_n`, `ack64_n`, `trdy_n` and `stop_n` are high.
- R2: The clock in which FRAME# is first seen low in idle is the address phase. For a claimed cycle, `loc_claim` rises two clocks after the address phase. While `loc_claim` is high, `loc_addr` and `loc_cmd` hold the address and command captured in that address phase.
- R3: An address matches window i when `(addr & BAR_MASK[i]) == (BAR_BASE[i] & BAR_MASK[i])`. The lowest-numbered matching window wins. `loc_hit` is one-hot, with bit i meaning window i, and it is valid while `loc_claim` is high.
- R4: Only the memory-read commands 4'b0110, 4'b1100 and 4'b1110 are claimed, and only when `req64_n` is low in the address phase. Any other command, or a cycle with `req64_n` high, leaves every driver enable low.
- R5: In a claimed cycle, `ctl_oe` and `ad_oe` rise two clocks after the address phase, with every control output still high. DEVSEL# and ACK64# go low one clock later.
- R6: `par_oe` follows `ad_oe` with exactly one clock of delay.
- R7: TRDY# is low during the data phases exactly when the holding register is full. The local agent transfers data (`loc_xfer`) when `loc_valid` is high and the register is empty or is being emptied by a non-final phase. PCI data phases return the local words in the order they were transferred.
- R8: A data phase completes on an edge where IRDY# and TRDY# are both low. It is the final one if FRAME# is high at that edge.
- R9: In the clock after the final phase, `ctl_oe` stays high, DEVSEL#, ACK64#, TRDY# and STOP# are all high, and `ad_oe` is low. In the clock after that, `ctl_oe` is low. STOP# is never asserted.
- R10: On a miss or an ignored cycle, no driver is enabled until the bus goes idle, and the next address phase is then handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | FRAME# from the master |
| req64_n | input | 1 | REQ64# from the master |
| irdy_n | input | 1 | IRDY# from the master |
| ad_in | input | AW | Low half of AD, sampled in the address phase |
| cbe_in | input | CW | C/BE[3:0], sampled in the address phase |
| ad_out | output | DW | Read data driven onto AD[63:0] |
| ad_oe | output | 1 | Drive enable for AD[63:0] |
| par_oe | output | 1 | Drive enable for the parity lines |
| ctl_oe | output | 1 | Drive enable for DEVSEL#, ACK64#, TRDY# and STOP# |
| devsel_n | output | 1 | DEVSEL# value |
| ack64_n | output | 1 | ACK64# value |
| trdy_n | output | 1 | TRDY# value |
| stop_n | output | 1 | STOP# value |
| loc_claim | output | 1 | A claimed read is in progress |
| loc_hit | output | NUM_BARS | One-hot code of the matched window |
| loc_addr | output | AW | Latched address |
| loc_cmd | output | CW | Latched command |
| loc_data | input | DW | Read data from the local agent |
| loc_valid | input | 1 | `loc_data` is valid |
| loc_accept | output | 1 | The block can take a word this clock |
| loc_xfer | output | 1 | A local word is transferred at the next edge |

## Verification
The assertions assume a well-behaved master on the bus side:
- A new address phase starts only when the bus is idle, never during the release clock.
- FRAME# goes high only while IRDY# is low, and the two are released together at the end of a cycle.
- REQ64# follows FRAME#.

The bench driver builds every cycle from these rules. It counts completed phases to decide when to raise FRAME#. It inserts master wait states only while more than one phase remains. Local-side stalls are single-clock drops of `loc_valid`, which are always legal for this block.

// File: rtl/pci64t_pkg.sv
package pci64t_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_CLAIM,
        ST_DATA,
        ST_TURN,
        ST_MISS
    } tgt_state_e;

    localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
    localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;

    function automatic logic is_mem_read(input logic [3:0] cmd);
        return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_RD_MULT) || (cmd == CMD_MEM_RD_LINE);
    endfunction

endpackage

// File: rtl/pci64t_bar_match.sv
module pci64t_bar_match #(
    parameter int NUM_BARS = 6,
    parameter int AW       = 32,
    parameter logic [NUM_BARS-1:0][AW-1:0] BASES = '0,
    parameter logic [NUM_BARS-1:0][AW-1:0] MASKS = '0
) (
    input  logic [AW-1:0]       addr,
    output logic [NUM_BARS-1:0] hit_oh,
    output logic                any_hit
);

    logic [NUM_BARS-1:0] match;

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_win
        assign match[g] = ((addr & MASKS[g]) == (BASES[g] & MASKS[g]));
    end

    // lowest index wins: last assignment in a descending scan
    always_comb begin
        hit_oh = '0;
        for (int i = NUM_BARS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_oh    = '0;
                hit_oh[i] = 1'b1;
            end
        end
    end

    assign any_hit = |match;

endmodule

// File: rtl/pci64t_rdbuf.sv
module pci64t_rdbuf #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic          unload,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          full
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            dout <= '0;
        end else if (clear) begin
            full <= 1'b0;
        end else if (load) begin
            full <= 1'b1;
            dout <= din;
        end else if (unload) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/pci64t_rd_target.sv
module pci64t_rd_target
    import pci64t_pkg::*;
#(
    parameter int NUM_BARS = 6,
    parameter int AW       = 32,
    parameter int DW       = 64,
    parameter int CW       = 4,
    parameter logic [NUM_BARS-1:0][AW-1:0] BAR_BASE = {
        32'h5000_0000, 32'h4000_0000, 32'h3000_0000,
        32'h1000_0000, 32'h2000_0000, 32'h1000_0000},
    parameter logic [NUM_BARS-1:0][AW-1:0] BAR_MASK = {
        32'hF000_0000, 32'hFFFF_FF00, 32'hFFF0_0000,
        32'hFF00_0000, 32'hFFFF_0000, 32'hFFFF_F000}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_n,
    input  logic                req64_n,
    input  logic                irdy_n,
    input  logic [AW-1:0]       ad_in,
    input  logic [CW-1:0]       cbe_in,
    output logic [DW-1:0]       ad_out,
    output logic                ad_oe,
    output logic                par_oe,
    output logic                ctl_oe,
    output logic                devsel_n,
    output logic                ack64_n,
    output logic                trdy_n,
    output logic                stop_n,
    output logic                loc_claim,
    output logic [NUM_BARS-1:0] loc_hit,
    output logic [AW-1:0]       loc_addr,
    output logic [CW-1:0]       loc_cmd,
    input  logic [DW-1:0]       loc_data,
    input  logic                loc_valid,
    output logic                loc_accept,
    output logic                loc_xfer
);

    tgt_state_e state, state_nx;

    logic                r64_q;
    logic [NUM_BARS-1:0] dec_oh;
    logic                dec_any;
    logic                claimable;
    logic                buf_full;
    logic                pci_xfer;
    logic                last_xfer;

    // address window decode on the latched address
    pci64t_bar_match #(
        .NUM_BARS (NUM_BARS),
        .AW       (AW),
        .BASES    (BAR_BASE),
        .MASKS    (BAR_MASK)
    ) u_dec (
        .addr    (loc_addr),
        .hit_oh  (dec_oh),
        .any_hit (dec_any)
    );

    assign claimable = dec_any && r64_q && is_mem_read(loc_cmd);
    assign pci_xfer  = (state == ST_DATA) && buf_full && !irdy_n;
    assign last_xfer = pci_xfer && frame_n;

    assign loc_accept = (state == ST_DATA) && (!buf_full || (pci_xfer && !frame_n));
    assign loc_xfer   = loc_accept && loc_valid;

    pci64t_rdbuf #(.DW(DW)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state != ST_DATA),
        .load   (loc_xfer),
        .unload (pci_xfer),
        .din    (loc_data),
        .dout   (ad_out),
        .full   (buf_full)
    );

    // address phase capture and window code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_addr <= '0;
            loc_cmd  <= '0;
            r64_q    <= 1'b0;
            loc_hit  <= '0;
        end else begin
            if (state == ST_IDLE && !frame_n) begin
                loc_addr <= ad_in;
                loc_cmd  <= cbe_in;
                r64_q    <= !req64_n;
            end
            if (state == ST_DECODE) begin
                loc_hit <= dec_oh;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (!frame_n) state_nx = ST_DECODE;
            ST_DECODE: state_nx = claimable ? ST_CLAIM : ST_MISS;
            ST_CLAIM:  state_nx = ST_DATA;
            ST_DATA:   if (last_xfer) state_nx = ST_TURN;
            ST_TURN:   state_nx = ST_IDLE;
            ST_MISS:   if (frame_n && irdy_n) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs decoded from state
    always_comb begin
        ad_oe     = 1'b0;
        par_oe    = 1'b0;
        ctl_oe    = 1'b0;
        devsel_n  = 1'b1;
        ack64_n   = 1'b1;
        trdy_n    = 1'b1;
        stop_n    = 1'b1;
        loc_claim = 1'b0;
        unique case (state)
            ST_CLAIM: begin
                ctl_oe    = 1'b1;
                ad_oe     = 1'b1;
                loc_claim = 1'b1;
            end
            ST_DATA: begin
                ctl_oe    = 1'b1;
                ad_oe     = 1'b1;
                par_oe    = 1'b1;
                devsel_n  = 1'b0;
                ack64_n   = 1'b0;
                trdy_n    = !buf_full;
                loc_claim = 1'b1;
            end
            ST_TURN: begin
                ctl_oe = 1'b1;
                par_oe = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/pci64t_rd_chk.sv
module pci64t_rd_chk #(
    parameter int NUM_BARS = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_n,
    input logic                irdy_n,
    input logic                ad_oe,
    input logic                par_oe,
    input logic                ctl_oe,
    input logic                devsel_n,
    input logic                ack64_n,
    input logic                trdy_n,
    input logic                stop_n,
    input logic                loc_claim,
    input logic [NUM_BARS-1:0] loc_hit
);

    p_hit_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        loc_claim |-> ($onehot0(loc_hit) && loc_hit != '0));

    p_enable_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_oe) |-> (ad_oe && devsel_n && ack64_n && trdy_n));

    p_claim_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_oe) |=> (!devsel_n && !ack64_n));

    p_devsel_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !devsel_n |-> ctl_oe);

    p_par_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe == $past(ad_oe));

    p_trdy_claimed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> (!devsel_n && ad_oe));

    p_turn_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && !devsel_n && !trdy_n && !irdy_n && frame_n) |=>
        (ctl_oe && devsel_n && ack64_n && trdy_n && stop_n && !ad_oe));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && !devsel_n && !trdy_n && !irdy_n && frame_n) |-> ##2 !ctl_oe);

    p_no_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_n);

endmodule

bind pci64t_rd_target pci64t_rd_chk #(.NUM_BARS(NUM_BARS)) u_chk (.*);

// File: tb/sim_pci64t_rd_target.sv
`timescale 1ns/1ps
module sim_pci64t_rd_target;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, req64_n = 1'b1, irdy_n = 1'b1;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_in = '0;
    logic [63:0] ad_out;
    logic        ad_oe, par_oe, ctl_oe, devsel_n, ack64_n, trdy_n, stop_n;
    logic        loc_claim;
    logic [5:0]  loc_hit;
    logic [31:0] loc_addr;
    logic [3:0]  loc_cmd;
    logic [63:0] loc_data = '0;
    logic        loc_valid = 1'b0;
    logic        loc_accept, loc_xfer;

    int n_chk = 0, n_bad = 0;
    logic [63:0] exp_q[$];
    logic [31:0] cur_tag = '0;
    int          stall_at = 99;

    always #2 clk = ~clk;

    pci64t_rd_target u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // local agent: supplies words tag:index, stalls once at stall_at
    int idx = 0, lcyc = 0;
    bit took = 1'b0;
    always begin
        @(negedge clk);
        if (!loc_claim) begin
            idx = 0; lcyc = 0; took = 1'b0;
        end else begin
            if (took) idx++;
            lcyc++;
        end
        loc_data  = {cur_tag, 32'(idx)};
        loc_valid = (lcyc != stall_at);
        #1 took = loc_xfer;
    end

    // scoreboard monitor: each PCI data phase pops one expected word
    always begin
        @(negedge clk);
        #2;
        if (ctl_oe && !trdy_n && !irdy_n) begin
            if (exp_q.size() == 0) chk(1'b0, "R7 extra phase", ad_out, 64'h0);
            else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                chk(ad_out == e, "R7 data order", ad_out, e);
            end
        end
    end

    task automatic do_read(input logic [31:0] addr, input logic [3:0] cmd, input bit r64,
                           input int n, input int wait_at, input bit exp_claim,
                           input logic [5:0] exp_hit);
        int c = 0;
        int done = 0;
        cur_tag = addr;
        @(negedge clk);
        frame_n = 1'b0; req64_n = !r64; irdy_n = 1'b1; ad_in = addr; cbe_in = cmd;
        if (exp_claim) for (int k = 0; k < n; k++) exp_q.push_back({addr, 32'(k)});
        if (!exp_claim) begin
            for (int k = 1; k <= 8; k++) begin
                @(negedge clk);
                frame_n = 1'b1; req64_n = 1'b1; irdy_n = (k >= 6); ad_in = '0;
                #2;
                chk(!ctl_oe && !ad_oe && !loc_claim && devsel_n,
                    exp_claim ? "R10" : "R4/R10 ignored", {61'h0, ctl_oe, ad_oe, loc_claim}, 64'h0);
            end
            return;
        end
        while (done < n && c < 200) begin
            @(negedge clk);
            c++;
            ad_in = '0;
            if (n - done <= 1) begin
                frame_n = 1'b1; irdy_n = 1'b0;
            end else begin
                frame_n = 1'b0; irdy_n = (c == wait_at);
            end
            req64_n = r64 ? frame_n : 1'b1;
            #2;
            if (c == 1) chk(!ctl_oe && !ad_oe && !loc_claim, "R5 no early enable",
                            {61'h0, ctl_oe, ad_oe, loc_claim}, 64'h0);
            if (c == 2) begin
                chk(ctl_oe && ad_oe && devsel_n && ack64_n && trdy_n, "R5 enables before claim",
                    {59'h0, ctl_oe, ad_oe, devsel_n, ack64_n, trdy_n}, 64'h1F);
                chk(!par_oe, "R6 parity off", {63'h0, par_oe}, 64'h0);
                chk(loc_claim && loc_addr == addr && loc_cmd == cmd, "R2 local address/command",
                    {27'h0, loc_claim, loc_cmd, loc_addr}, {27'h0, 1'b1, cmd, addr});
                chk(loc_hit == exp_hit, "R3 window code", {58'h0, loc_hit}, {58'h0, exp_hit});
            end
            if (c == 3) begin
                chk(!devsel_n && !ack64_n, "R5 claim asserted",
                    {62'h0, devsel_n, ack64_n}, 64'h0);
                chk(par_oe, "R6 parity on", {63'h0, par_oe}, 64'h1);
            end
            if (c == 3 && stall_at != 99)
                chk(trdy_n, "R7 TRDY# waits for data", {63'h0, trdy_n}, 64'h1);
            if (ctl_oe && !trdy_n && !irdy_n) done++;
        end
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1; req64_n = 1'b1;
        #2;
        chk(devsel_n && trdy_n && done == n, "R8 final phase ended cycle",
            {30'h0, devsel_n, trdy_n, 32'(done)}, {30'h0, 2'b11, 32'(n)});
        chk(ctl_oe && ack64_n && stop_n && !ad_oe, "R9 driven-high clock",
            {60'h0, ctl_oe, ack64_n, stop_n, ad_oe}, 64'hE);
        @(negedge clk);
        #2;
        chk(!ctl_oe && !par_oe && !loc_claim, "R9 released",
            {61'h0, ctl_oe, par_oe, loc_claim}, 64'h0);
        chk(exp_q.size() == 0, "R7 all words delivered", 64'(exp_q.size()), 64'h0);
        exp_q.delete();
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(!ctl_oe && !ad_oe && !par_oe && !loc_claim && devsel_n && ack64_n && trdy_n && stop_n,
            "R1 reset state", {56'h0, ctl_oe, ad_oe, par_oe, loc_claim, devsel_n, ack64_n, trdy_n, stop_n},
            64'h0F);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        chk(!ctl_oe && !ad_oe && !loc_claim, "R1 idle after reset",
            {61'h0, ctl_oe, ad_oe, loc_claim}, 64'h0);

        stall_at = 99;
        do_read(32'h1000_0040, 4'b0110, 1'b1, 1, 0, 1'b1, 6'b000001);   // single, window 0
        do_read(32'h2000_0100, 4'b1100, 1'b1, 4, 0, 1'b1, 6'b000010);   // burst, window 1
        do_read(32'h1000_2000, 4'b1110, 1'b1, 3, 5, 1'b1, 6'b000100);   // master wait, window 2
        stall_at = 1;
        do_read(32'h3000_0008, 4'b0110, 1'b1, 4, 0, 1'b1, 6'b001000);   // local stall, window 3
        stall_at = 3;
        do_read(32'h4000_0010, 4'b1100, 1'b1, 2, 0, 1'b1, 6'b010000);   // window 4
        stall_at = 99;
        do_read(32'h5123_4560, 4'b0110, 1'b1, 5, 6, 1'b1, 6'b100000);   // window 5
        do_read(32'h1000_0000, 4'b0111, 1'b1, 1, 0, 1'b0, 6'b000000);   // R4 write command
        do_read(32'h1000_0000, 4'b0110, 1'b0, 1, 0, 1'b0, 6'b000000);   // R4 no REQ64#
        do_read(32'h6000_0000, 4'b0110, 1'b1, 1, 0, 1'b0, 6'b000000);   // R10 miss
        do_read(32'h1000_0FF8, 4'b1110, 1'b1, 2, 0, 1'b1, 6'b000001);   // R10 normal after miss
        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule